// File: doc/BRIEF.md
# Re-access Counter Update Engine

This block maintains a small saturating re-access counter that travels with a cache line's directory entry as the line moves among a private second-level cache, a shared last-level cache and main memory. Each cycle it may accept one migration event for one line. The event names the kind of traffic, the line address and the entry's current extension state: the 3-bit counter and the conflict, protect and access flags. It also carries whether the regulator directory holds the address. The block returns the rewritten counter and flags, together with the structure that should hold the entry next.

The counter rises only for suspicious traffic. That means a re-access to a line that was pushed out of the second level by a directory conflict, or a refill from memory of a line the regulator directory still tracks. When a line leaves the caches for memory, the counter is corrected for defensive preloads that went unused. It is then handed to the regulator directory.

When the rewritten counter is at or above a programmable threshold, the block raises one of two requests. It asks for a preload when the entry is headed for the regulator directory. It asks for a lock when the entry sits in the last-level directory, and that lock pins the entry there. All results appear one cycle after the event.

Top module: `rac_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `upd_valid`, `preload_req`, `lock_req` and all update fields are 0.
- R2: Event kind 2'b00 (hit in L1 or L2) returns counter and all three flags unchanged, with `upd_dest` 2'b00 (second-level directory), one cycle later.
- R3: Event kind 2'b01 (L2 miss, LLC hit) returns counter plus the conflict flag and clears the conflict flag. It keeps protect and access, and sets `upd_dest` to 2'b00 unless R9 applies.
- R4: Event kind 2'b10 (miss in both levels) with `reg_hit`=1 returns the incoming counter plus one, with all flags 0 and `upd_dest` 2'b00.
- R5: Event kind 2'b10 with `reg_hit`=0 returns counter 0 and all flags 0, with `upd_dest` 2'b00.
- R6: Event kind 2'b11 (leaving to memory) returns counter minus protect plus access, with all flags 0 and `upd_dest` 2'b10 (regulator directory).
- R7: Counter arithmetic saturates at 7 when rising and at 0 when falling. It never wraps.
- R8: On an event of kind 2'b11 whose updated counter is at or above a nonzero `thresh`, `preload_req` pulses for one cycle with the results, and `act_addr` carries the event address.
- R9: On an event of kind 2'b01 whose updated counter is at or above a nonzero `thresh`, `lock_req` pulses for one cycle with `act_addr` equal to the event address. `upd_dest` is then 2'b01 (LLC directory).
- R10: At most one of `preload_req` and `lock_req` is high in any cycle. Neither is raised for event kinds 2'b00 and 2'b10. A `thresh` of 0 suppresses both.
- R11: A cycle with `ev_valid`=0 yields `upd_valid`, `preload_req` and `lock_req` all 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 2 | Event kind: 00 hit, 01 LLC hit, 10 miss both, 11 to memory |
| ev_addr | input | ADDR_W | Line address of the event |
| cur_count | input | 3 | Entry's current re-access counter (regulator copy on a refill) |
| cur_conflict | input | 1 | Line last left L2 through a directory conflict |
| cur_protect | input | 1 | Line was brought in by a defensive preload |
| cur_access | input | 1 | Preloaded line was used while cached |
| reg_hit | input | 1 | Regulator directory holds the address |
| thresh | input | 3 | Action threshold; 0 disables actions |
| upd_valid | output | 1 | Update results are valid |
| upd_count | output | 3 | Rewritten counter |
| upd_conflict | output | 1 | Rewritten conflict flag |
| upd_protect | output | 1 | Rewritten protect flag |
| upd_access | output | 1 | Rewritten access flag |
| upd_dest | output | 2 | Destination: 00 L2 dir, 01 LLC dir, 10 regulator dir |
| preload_req | output | 1 | One-cycle preload request |
| lock_req | output | 1 | One-cycle lock request |
| act_addr | output | ADDR_W | Address for the raised request |

## Verification
Some properties are checked on every cycle. A hit leaves the entry untouched. An untracked refill starts from zero. A re-access after a conflict never lowers the counter. The two requests never coincide, each comes with a valid update to the matching destination, and each echoes the event address. A zero threshold silences both requests, and an idle cycle produces no output. The scenarios cover the arithmetic itself: preload correction on eviction, clamping at both ends, and the exact threshold boundary where a request first appears or stays off.

// File: rtl/rac_pkg.sv
package rac_pkg;

    localparam int CNT_W   = 3;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    typedef enum logic [1:0] {
        EV_HIT    = 2'b00,
        EV_LLC    = 2'b01,
        EV_REFILL = 2'b10,
        EV_EVICT  = 2'b11
    } ev_kind_e;

    typedef enum logic [1:0] {
        DST_L2  = 2'b00,
        DST_LLC = 2'b01,
        DST_REG = 2'b10
    } dest_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             conflict;
        logic             protect;
        logic             access;
    } ext_t;

    // clamped counter adjust: c + up - down, held inside [0, CNT_MAX]
    function automatic logic [CNT_W-1:0] sat_adj(input logic [CNT_W-1:0] c,
                                                 input logic up,
                                                 input logic down);
        int v;
        v = int'(c) + int'(up) - int'(down);
        if (v < 0)       v = 0;
        if (v > CNT_MAX) v = CNT_MAX;
        return CNT_W'(v);
    endfunction

endpackage

// File: rtl/rac_migrate.sv
module rac_migrate
    import rac_pkg::*;
(
    input  ev_kind_e kind,
    input  ext_t     cur,
    input  logic     reg_hit,
    output ext_t     nxt,
    output dest_e    dest
);

    always_comb begin
        nxt  = cur;
        dest = DST_L2;
        unique case (kind)
            EV_HIT: begin
                nxt = cur;
            end
            EV_LLC: begin
                nxt.count    = sat_adj(cur.count, cur.conflict, 1'b0);
                nxt.conflict = 1'b0;
            end
            EV_REFILL: begin
                nxt = '0;
                if (reg_hit) nxt.count = sat_adj(cur.count, 1'b1, 1'b0);
            end
            EV_EVICT: begin
                nxt       = '0;
                nxt.count = sat_adj(cur.count, cur.access, cur.protect);
                dest      = DST_REG;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rac_trigger.sv
module rac_trigger
    import rac_pkg::*;
(
    input  ev_kind_e         kind,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thresh,
    input  dest_e            dest_in,
    output logic             preload,
    output logic             lock,
    output dest_e            dest_out
);

    logic armed;

    always_comb begin
        armed    = (thresh != '0) && (count >= thresh);
        preload  = armed && (kind == EV_EVICT);
        lock     = armed && (kind == EV_LLC);
        dest_out = lock ? DST_LLC : dest_in;
    end

endmodule

// File: rtl/rac_engine.sv
module rac_engine
    import rac_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [1:0]        ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [2:0]        cur_count,
    input  logic              cur_conflict,
    input  logic              cur_protect,
    input  logic              cur_access,
    input  logic              reg_hit,
    input  logic [2:0]        thresh,
    output logic              upd_valid,
    output logic [2:0]        upd_count,
    output logic              upd_conflict,
    output logic              upd_protect,
    output logic              upd_access,
    output logic [1:0]        upd_dest,
    output logic              preload_req,
    output logic              lock_req,
    output logic [ADDR_W-1:0] act_addr
);

    ev_kind_e kind;
    ext_t     cur_ext;
    ext_t     nxt_ext;
    dest_e    base_dest;
    dest_e    fin_dest;
    logic     pl_c;
    logic     lk_c;

    ext_t              ext_q;
    logic [1:0]        dest_q;

    assign kind    = ev_kind_e'(ev_kind);
    assign cur_ext = '{count: cur_count, conflict: cur_conflict,
                       protect: cur_protect, access: cur_access};

    rac_migrate u_migrate (
        .kind    (kind),
        .cur     (cur_ext),
        .reg_hit (reg_hit),
        .nxt     (nxt_ext),
        .dest    (base_dest)
    );

    rac_trigger u_trigger (
        .kind     (kind),
        .count    (nxt_ext.count),
        .thresh   (thresh),
        .dest_in  (base_dest),
        .preload  (pl_c),
        .lock     (lk_c),
        .dest_out (fin_dest)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_valid   <= 1'b0;
            ext_q       <= '0;
            dest_q      <= '0;
            preload_req <= 1'b0;
            lock_req    <= 1'b0;
            act_addr    <= '0;
        end else begin
            upd_valid   <= ev_valid;
            preload_req <= ev_valid && pl_c;
            lock_req    <= ev_valid && lk_c;
            if (ev_valid) begin
                ext_q    <= nxt_ext;
                dest_q   <= fin_dest;
                act_addr <= ev_addr;
            end
        end
    end

    assign upd_count    = ext_q.count;
    assign upd_conflict = ext_q.conflict;
    assign upd_protect  = ext_q.protect;
    assign upd_access   = ext_q.access;
    assign upd_dest     = dest_q;

endmodule

// File: rtl/rac_checker.sv
module rac_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_valid,
    input logic [1:0]        ev_kind,
    input logic [ADDR_W-1:0] ev_addr,
    input logic [2:0]        cur_count,
    input logic              cur_conflict,
    input logic              cur_protect,
    input logic              cur_access,
    input logic              reg_hit,
    input logic [2:0]        thresh,
    input logic              upd_valid,
    input logic [2:0]        upd_count,
    input logic              upd_conflict,
    input logic              upd_protect,
    input logic              upd_access,
    input logic [1:0]        upd_dest,
    input logic              preload_req,
    input logic              lock_req,
    input logic [ADDR_W-1:0] act_addr
);

    p_hit_keeps_r2: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == 2'b00) |=>
            (upd_count == $past(cur_count) && upd_conflict == $past(cur_conflict) &&
             upd_protect == $past(cur_protect) && upd_access == $past(cur_access) &&
             upd_dest == 2'b00));

    p_llc_never_drops_r3: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == 2'b01) |=> (upd_count >= $past(cur_count) && !upd_conflict));

    p_fresh_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == 2'b10 && !reg_hit) |=>
            (upd_count == 3'd0 && !upd_conflict && !upd_protect && !upd_access));

    p_preload_dest_r8: assert property (@(posedge clk) disable iff (rst)
        preload_req |-> (upd_valid && upd_dest == 2'b10));

    p_lock_dest_r9: assert property (@(posedge clk) disable iff (rst)
        lock_req |-> (upd_valid && upd_dest == 2'b01));

    p_action_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && (ev_kind == 2'b01 || ev_kind == 2'b11)) |=>
            ((preload_req || lock_req) -> act_addr == $past(ev_addr)));

    p_single_action_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({preload_req, lock_req}));

    p_zero_thresh_r10: assert property (@(posedge clk) disable iff (rst)
        (thresh == 3'd0) |=> (!preload_req && !lock_req));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !ev_valid |=> (!upd_valid && !preload_req && !lock_req));

endmodule

bind rac_engine rac_checker #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_rac_engine.sv
module test_rac_engine;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          ev_valid;
    logic [1:0]    ev_kind;
    logic [AW-1:0] ev_addr;
    logic [2:0]    cur_count;
    logic          cur_conflict, cur_protect, cur_access, reg_hit;
    logic [2:0]    thresh;
    logic          upd_valid, upd_conflict, upd_protect, upd_access;
    logic [2:0]    upd_count;
    logic [1:0]    upd_dest;
    logic          preload_req, lock_req;
    logic [AW-1:0] act_addr;

    always #10 clk = ~clk;

    rac_engine #(.ADDR_W(AW)) i_rac_engine (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr),
        .cur_count(cur_count), .cur_conflict(cur_conflict), .cur_protect(cur_protect),
        .cur_access(cur_access), .reg_hit(reg_hit), .thresh(thresh),
        .upd_valid(upd_valid), .upd_count(upd_count), .upd_conflict(upd_conflict),
        .upd_protect(upd_protect), .upd_access(upd_access), .upd_dest(upd_dest),
        .preload_req(preload_req), .lock_req(lock_req), .act_addr(act_addr)
    );

    typedef struct {
        logic          vld;
        int            cnt;
        logic          cf, pr, ac;
        int            dst;
        logic          pl, lk;
        logic [AW-1:0] addr;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // independent reference of the requirements
    task automatic send(input int kind, input int c, input bit cf, input bit pr,
                        input bit ac, input bit rh, input int th,
                        input logic [AW-1:0] a, input string tag);
        exp_t e;
        int   v;
        e.vld = 1; e.addr = a; e.tag = tag; e.pl = 0; e.lk = 0;
        e.cf = 0; e.pr = 0; e.ac = 0; e.dst = 0;
        if (kind == 0) begin
            e.cnt = c; e.cf = cf; e.pr = pr; e.ac = ac;
        end else if (kind == 1) begin
            v = c + (cf ? 1 : 0);
            e.cnt = (v > 7) ? 7 : v; e.pr = pr; e.ac = ac;
            if (th != 0 && e.cnt >= th) begin e.lk = 1; e.dst = 1; end
        end else if (kind == 2) begin
            e.cnt = rh ? ((c == 7) ? 7 : c + 1) : 0;
        end else begin
            v = c - (pr ? 1 : 0) + (ac ? 1 : 0);
            e.cnt = (v < 0) ? 0 : ((v > 7) ? 7 : v);
            e.dst = 2;
            if (th != 0 && e.cnt >= th) e.pl = 1;
        end
        @(negedge clk);
        ev_valid = 1; ev_kind = kind[1:0]; ev_addr = a; cur_count = c[2:0];
        cur_conflict = cf; cur_protect = pr; cur_access = ac; reg_hit = rh; thresh = th[2:0];
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        e.vld = 0; e.cnt = 0; e.cf = 0; e.pr = 0; e.ac = 0; e.dst = 0;
        e.pl = 0; e.lk = 0; e.addr = '0; e.tag = tag;
        @(negedge clk);
        ev_valid = 0; ev_kind = 2'b11; cur_count = 3'd7; thresh = 3'd1;
        q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                bit   bad;
                e = q.pop_front();
                n_checks++;
                bad = (upd_valid !== e.vld) || (preload_req !== e.pl) || (lock_req !== e.lk);
                if (e.vld)
                    bad = bad || (upd_count !== 3'(e.cnt)) || (upd_conflict !== e.cf) ||
                          (upd_protect !== e.pr) || (upd_access !== e.ac) ||
                          (upd_dest !== 2'(e.dst));
                if (e.pl || e.lk) bad = bad || (act_addr !== e.addr);
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s: got v=%0b c=%0d f=%0b%0b%0b d=%0d pl=%0b lk=%0b a=%h, exp v=%0b c=%0d f=%0b%0b%0b d=%0d pl=%0b lk=%0b a=%h",
                        e.tag, upd_valid, upd_count, upd_conflict, upd_protect, upd_access,
                        upd_dest, preload_req, lock_req, act_addr,
                        e.vld, e.cnt, e.cf, e.pr, e.ac, e.dst, e.pl, e.lk, e.addr);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout, exp completion");
        report();
    end

    initial begin
        rst = 1; ev_valid = 0; ev_kind = 0; ev_addr = 0; cur_count = 0;
        cur_conflict = 0; cur_protect = 0; cur_access = 0; reg_hit = 0; thresh = 3;
        repeat (3) @(posedge clk);
        #5;
        n_checks++;
        if (upd_valid || preload_req || lock_req || upd_count != 0 || upd_dest != 0) begin
            n_fail++;
            $display("FAIL R1: got v=%0b pl=%0b lk=%0b c=%0d, exp all 0",
                     upd_valid, preload_req, lock_req, upd_count);
        end
        @(negedge clk);
        rst = 0;

        // R2 hit keeps everything, even above threshold
        send(0, 5, 1, 1, 0, 0, 3, 32'h100, "R2");
        send(0, 2, 0, 0, 1, 1, 1, 32'h104, "R2");
        // R3 re-access after conflict / after plain replacement
        send(1, 1, 1, 1, 1, 0, 3, 32'h200, "R3");
        send(1, 1, 0, 0, 1, 0, 3, 32'h204, "R3");
        // R9 lock exactly at threshold, and none just below
        send(1, 2, 1, 0, 0, 0, 3, 32'h2A0, "R9");
        send(1, 1, 1, 0, 0, 0, 3, 32'h2A4, "R9");
        // R4 tracked refill, R5 untracked refill
        send(2, 3, 1, 1, 1, 1, 7, 32'h300, "R4");
        send(2, 6, 1, 1, 1, 0, 3, 32'h304, "R5");
        // R10 refill past threshold raises nothing
        send(2, 5, 0, 0, 0, 1, 2, 32'h308, "R10");
        // R6 eviction correction
        send(3, 4, 1, 1, 0, 0, 0, 32'h400, "R6");
        send(3, 2, 0, 0, 1, 0, 0, 32'h404, "R6");
        send(3, 3, 0, 1, 1, 0, 0, 32'h408, "R6");
        // R7 saturation both ends
        send(2, 7, 0, 0, 0, 1, 0, 32'h500, "R7");
        send(3, 0, 0, 1, 0, 0, 0, 32'h504, "R7");
        send(3, 7, 0, 0, 1, 0, 0, 32'h508, "R7");
        send(1, 7, 1, 0, 0, 0, 0, 32'h50C, "R7");
        // R8 preload at and below threshold
        send(3, 3, 0, 0, 0, 0, 3, 32'hABC0, "R8");
        send(3, 3, 0, 1, 0, 0, 3, 32'hABC4, "R8");
        send(3, 1, 0, 0, 1, 0, 2, 32'hABC8, "R8");
        // R10 threshold 0 disables, threshold 1 fires easily
        send(3, 7, 0, 0, 0, 0, 0, 32'h600, "R10");
        send(1, 6, 1, 0, 0, 0, 0, 32'h604, "R10");
        send(1, 0, 1, 0, 0, 0, 1, 32'h608, "R9");
        // R11 idle cycles between and after events
        idle("R11");
        send(3, 5, 0, 0, 0, 0, 4, 32'h700, "R8");
        idle("R11");
        idle("R11");
        @(negedge clk);
        ev_valid = 0;
        repeat (3) @(posedge clk);
        #6;
        done = 1;
        report();
    end

endmodule